// File: doc/BRIEF.md
# Stereo-to-Mono PCM Receiver Front End

This block takes a serial stereo PCM stream (bit clock, word clock and data) and produces one mono sample per stereo frame for a downstream amplifier. All three serial lines are oversampled by a free-running system clock, so the block has a single clock domain. A 2-bit mode input, already decoded by an upstream comparator stage, selects the left word, the right word, or the floor average of both. The fourth code shuts the output off.

The block also watches the bit clock. If no bit-clock edge arrives within a timeout counted in system-clock cycles, it enters standby and lowers the output-enable. The amplifier's output stage then goes to high impedance. The block times the word-clock period in system-clock cycles and classes the sample rate into one of three bands. A downstream filter uses that band code to pick its lowpass profile.

After reset, after standby and after shutdown, the block needs one complete, correctly received frame before output-enable rises and samples flow again.

Top module: `pcm_mono_frontend`

## Requirements
- R1: Mode code 2'b01 selects the left word. Each mono sample equals the left word of its frame.
- R2: Mode code 2'b10 selects the right word. Each mono sample equals the right word of its frame.
- R3: Mode code 2'b11 outputs the sum of the two signed words, formed one bit wider than a sample and then shifted arithmetically right by one (floor of (L+R)/2). It never overflows, including at full-scale inputs.
- R4: Mode code 2'b00 is shutdown. While it is applied, `drive_en_o` is low, no valid strobe is issued, and `mono_o` reads zero from the next cycle on.
- R5: The serial format is I2S. Each word starts with its MSB one bit-clock rising edge after the word-clock change. Word clock low carries the left word. Data is sampled on bit-clock rising edges. Slots longer than SAMPLE_W bits keep their first SAMPLE_W bits.
- R6: If the bit clock shows no edge for more than IDLE_CYC system-clock cycles (plus the synchronizer delay), the block enters standby. `drive_en_o` goes low and `mono_o` reads zero.
- R7: After reset, standby or shutdown, the first complete frame is discarded. `drive_en_o` rises on it, and samples resume from the following frame. From reset or standby, the first frame only aligns the receiver, so two frames pass before the first sample.
- R8: `mono_vld_o` pulses for exactly one cycle per completed stereo frame while enabled, and only when `drive_en_o` was high on the cycle before.
- R9: The word-clock period P is counted in system-clock cycles between word-clock rising edges. The band code on `filt_band_o` is 2'b00 (voice) when P > CLK_HZ/30000, 2'b10 (high) when P < CLK_HZ/50000, and 2'b01 (middle) otherwise. Code 2'b11 never appears.
- R10: After reset, `filt_band_o` is 2'b00, `drive_en_o` is 0, `mono_vld_o` is 0 and `mono_o` is 0. The band code holds until the first full word-clock period has been measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk_i | input | 1 | Serial bit clock (asynchronous) |
| word_clk_i | input | 1 | Serial word clock, low = left (asynchronous) |
| ser_data_i | input | 1 | Serial audio data, MSB first |
| chan_mode_i | input | 2 | 00 off, 01 left, 10 right, 11 average |
| mono_o | output | SAMPLE_W | Selected mono sample, zero when disabled |
| mono_vld_o | output | 1 | One-cycle strobe per delivered sample |
| drive_en_o | output | 1 | Output-stage enable; low means high impedance |
| filt_band_o | output | 2 | Sample-rate band code for the filter |

## Verification
The assertions assume the serial clocks toggle slowly enough that each bit-clock phase lasts at least one system-clock cycle after synchronization. They also assume a stereo frame spans many system cycles, so completed frames never fall on adjacent cycles. The bench drives every bit-clock phase for two or more system cycles and keeps frames over sixty cycles long. It changes the mode only at frame boundaries, while the block is idle between bursts. Pauses between bursts stay shorter than the idle timeout except in the deliberate standby test.

// File: rtl/pcmfe_pkg.sv
package pcmfe_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_LEFT  = 2'b01,
        MODE_RIGHT = 2'b10,
        MODE_MIX   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        BAND_LOW  = 2'b00,
        BAND_MID  = 2'b01,
        BAND_HIGH = 2'b10
    } band_e;

    // synchronized copy of the three serial lines
    typedef struct packed {
        logic bck;
        logic wck;
        logic dat;
    } line_t;

    localparam int LINE_W = 3;

    // rate class from a measured period in system cycles
    function automatic band_e classify(input int unsigned period,
                                       input int unsigned lo_lim,
                                       input int unsigned hi_lim);
        if (period > lo_lim)
            return BAND_LOW;
        else if (period < hi_lim)
            return BAND_HIGH;
        return BAND_MID;
    endfunction

endpackage

// File: rtl/pcmfe_sync.sv
module pcmfe_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++)
                stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcmfe_i2s_rx.sv
module pcmfe_i2s_rx
    import pcmfe_pkg::*;
#(
    parameter int SW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush_i,
    input  line_t         line_i,
    output logic          frame_vld_o,
    output logic [SW-1:0] left_o,
    output logic [SW-1:0] right_o
);
    localparam int CNTW = $clog2(SW + 1);

    logic            bck_d;
    logic            rise;
    logic            boundary;
    logic            ws_prev;
    logic            aligned;
    logic            left_ok;
    logic [SW-1:0]   shreg;
    logic [CNTW-1:0] cnt;
    logic            take;
    logic [SW-1:0]   sh_nxt;
    logic [CNTW-1:0] cnt_nxt;
    logic            full;
    logic [SW-1:0]   left_q;
    logic [SW-1:0]   right_q;
    logic            vld_q;

    assign rise     = line_i.bck & ~bck_d;
    assign boundary = rise & (line_i.wck != ws_prev);

    always_comb begin
        take    = (cnt < CNTW'(SW));
        sh_nxt  = take ? {shreg[SW-2:0], line_i.dat} : shreg;
        cnt_nxt = cnt + {{(CNTW-1){1'b0}}, take};
        full    = (cnt_nxt == CNTW'(SW));
    end

    always_ff @(posedge clk) begin
        if (rst) bck_d <= 1'b0;
        else     bck_d <= line_i.bck;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            ws_prev <= 1'b0;
            aligned <= 1'b0;
            left_ok <= 1'b0;
            shreg   <= '0;
            cnt     <= '0;
            vld_q   <= 1'b0;
            if (rst) begin
                left_q  <= '0;
                right_q <= '0;
            end
        end else begin
            vld_q <= 1'b0;
            if (rise) begin
                ws_prev <= line_i.wck;
                if (boundary) begin
                    shreg   <= '0;
                    cnt     <= '0;
                    aligned <= 1'b1;
                    if (aligned && full) begin
                        if (!ws_prev) begin
                            left_q  <= sh_nxt;
                            left_ok <= 1'b1;
                        end else begin
                            left_ok <= 1'b0;
                            if (left_ok) begin
                                right_q <= sh_nxt;
                                vld_q   <= 1'b1;
                            end
                        end
                    end else begin
                        left_ok <= 1'b0;
                    end
                end else begin
                    shreg <= sh_nxt;
                    cnt   <= cnt_nxt;
                end
            end
        end
    end

    assign frame_vld_o = vld_q;
    assign left_o      = left_q;
    assign right_o     = right_q;
endmodule

// File: rtl/pcmfe_idle_watch.sv
module pcmfe_idle_watch #(
    parameter int IDLE_CYC = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic bck_i,
    output logic standby_o
);
    localparam int TW = $clog2(IDLE_CYC + 1);

    logic          bck_d;
    logic [TW-1:0] timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            bck_d <= 1'b0;
            timer <= '0;
        end else begin
            bck_d <= bck_i;
            if (bck_i != bck_d)
                timer <= TW'(IDLE_CYC);
            else if (timer != '0)
                timer <= timer - 1'b1;
        end
    end

    assign standby_o = (timer == '0);
endmodule

// File: rtl/pcmfe_rate_meter.sv
module pcmfe_rate_meter
    import pcmfe_pkg::*;
#(
    parameter int CLK_HZ  = 24576000,
    parameter int LOW_HZ  = 30000,
    parameter int HIGH_HZ = 50000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wck_i,
    output band_e band_o
);
    localparam int LO_LIM = CLK_HZ / LOW_HZ;
    localparam int HI_LIM = CLK_HZ / HIGH_HZ;
    localparam int CW     = $clog2(LO_LIM + 2) + 1;

    logic          wck_d;
    logic          measured;
    logic [CW-1:0] count;
    band_e         band_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wck_d    <= 1'b0;
            measured <= 1'b0;
            count    <= '0;
            band_q   <= BAND_LOW;
        end else begin
            wck_d <= wck_i;
            if (wck_i && !wck_d) begin
                if (measured)
                    band_q <= classify(32'(count), LO_LIM, HI_LIM);
                measured <= 1'b1;
                count    <= CW'(1);
            end else if (count != '1) begin
                count <= count + 1'b1;
            end
        end
    end

    assign band_o = band_q;
endmodule

// File: rtl/pcm_mono_frontend.sv
module pcm_mono_frontend
    import pcmfe_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2,
    parameter int CLK_HZ      = 24576000,
    parameter int IDLE_CYC    = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_clk_i,
    input  logic                word_clk_i,
    input  logic                ser_data_i,
    input  logic [1:0]          chan_mode_i,
    output logic [SAMPLE_W-1:0] mono_o,
    output logic                mono_vld_o,
    output logic                drive_en_o,
    output logic [1:0]          filt_band_o
);
    line_t               raw_line;
    line_t               sy_line;
    logic                standby;
    logic                frame_vld;
    logic [SAMPLE_W-1:0] left_w;
    logic [SAMPLE_W-1:0] right_w;
    band_e               band;
    mode_e               mode;
    logic [SAMPLE_W:0]   sum_w;
    logic [SAMPLE_W-1:0] pick;
    logic                live;
    logic                armed_q;
    logic [SAMPLE_W-1:0] sample_q;
    logic                vld_q;

    assign raw_line = '{bck: bit_clk_i, wck: word_clk_i, dat: ser_data_i};

    pcmfe_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_line),
        .q_o (sy_line)
    );

    pcmfe_i2s_rx #(.SW(SAMPLE_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (standby),
        .line_i      (sy_line),
        .frame_vld_o (frame_vld),
        .left_o      (left_w),
        .right_o     (right_w)
    );

    pcmfe_idle_watch #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .bck_i     (sy_line.bck),
        .standby_o (standby)
    );

    pcmfe_rate_meter #(.CLK_HZ(CLK_HZ)) u_rate (
        .clk    (clk),
        .rst    (rst),
        .wck_i  (sy_line.wck),
        .band_o (band)
    );

    assign mode  = mode_e'(chan_mode_i);
    assign sum_w = {left_w[SAMPLE_W-1], left_w} + {right_w[SAMPLE_W-1], right_w};

    always_comb begin
        unique case (mode)
            MODE_LEFT:  pick = left_w;
            MODE_RIGHT: pick = right_w;
            MODE_MIX:   pick = sum_w[SAMPLE_W:1];
            default:    pick = '0;
        endcase
    end

    assign live = armed_q && !standby && (mode != MODE_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            sample_q <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (standby || mode == MODE_OFF)
                armed_q <= 1'b0;
            else if (frame_vld)
                armed_q <= 1'b1;
            if (frame_vld && live) begin
                sample_q <= pick;
                vld_q    <= 1'b1;
            end else if (!live) begin
                sample_q <= '0;
            end
        end
    end

    assign mono_o      = sample_q;
    assign mono_vld_o  = vld_q;
    assign drive_en_o  = live;
    assign filt_band_o = band;
endmodule

// File: rtl/pcmfe_checker.sv
module pcmfe_checker #(
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CYC    = 256
) (
    input logic                clk,
    input logic                rst,
    input logic                bit_clk_i,
    input logic [1:0]          chan_mode_i,
    input logic [SAMPLE_W-1:0] mono_o,
    input logic                mono_vld_o,
    input logic                drive_en_o,
    input logic [1:0]          filt_band_o
);
    localparam int QUIET_LIM = IDLE_CYC + SYNC_STAGES + 4;
    localparam int QW        = $clog2(QUIET_LIM + 1);

    logic          bck_seen;
    logic [QW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst) begin
            bck_seen <= 1'b0;
            quiet    <= '0;
        end else begin
            bck_seen <= bit_clk_i;
            if (bit_clk_i != bck_seen)
                quiet <= '0;
            else if (quiet != QW'(QUIET_LIM))
                quiet <= quiet + 1'b1;
        end
    end

    AST_SHUT_OFF: assert property (@(posedge clk) disable iff (rst)
        (chan_mode_i == 2'b00) |-> !drive_en_o); // R4

    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
        !drive_en_o |=> (mono_o == '0)); // R4

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
        (quiet == QW'(QUIET_LIM)) |-> !drive_en_o); // R6

    AST_VLD_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
        mono_vld_o |-> $past(drive_en_o)); // R8

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        mono_vld_o |=> !mono_vld_o); // R8

    AST_BAND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        filt_band_o != 2'b11); // R9
endmodule

bind pcm_mono_frontend pcmfe_checker #(
    .SAMPLE_W    (SAMPLE_W),
    .SYNC_STAGES (SYNC_STAGES),
    .IDLE_CYC    (IDLE_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_clk_i   (bit_clk_i),
    .chan_mode_i (chan_mode_i),
    .mono_o      (mono_o),
    .mono_vld_o  (mono_vld_o),
    .drive_en_o  (drive_en_o),
    .filt_band_o (filt_band_o)
);

// File: tb/sim_pcm_mono_frontend.sv
module sim_pcm_mono_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int SW         = 8;
    localparam int CLK_HZ     = 4000000;
    localparam int IDLE_CYC   = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bit_clk = 1'b0;
    logic          word_clk = 1'b0;
    logic          ser_data = 1'b0;
    logic [1:0]    chan_mode = 2'b00;
    logic [SW-1:0] mono;
    logic          mono_vld;
    logic          drive_en;
    logic [1:0]    filt_band;

    int total = 0;
    int bad   = 0;
    int got_q[$];
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_mono_frontend #(
        .SAMPLE_W (SW),
        .CLK_HZ   (CLK_HZ),
        .IDLE_CYC (IDLE_CYC)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .bit_clk_i   (bit_clk),
        .word_clk_i  (word_clk),
        .ser_data_i  (ser_data),
        .chan_mode_i (chan_mode),
        .mono_o      (mono),
        .mono_vld_o  (mono_vld),
        .drive_en_o  (drive_en),
        .filt_band_o (filt_band)
    );

    always @(negedge clk)
        if (!rst && mono_vld) got_q.push_back(int'($signed(mono)));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic wsv, input logic dv, input int lo, input int hi);
        bit_clk  = 1'b0;
        word_clk = wsv;
        ser_data = dv;
        repeat (lo) @(negedge clk);
        bit_clk = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    task automatic send_frame(input int l, input int r, input int h, input int extra, input int pad);
        logic [SW-1:0] lb;
        logic [SW-1:0] rb;
        int slot;
        lb   = SW'(l);
        rb   = SW'(r);
        slot = SW + pad;
        for (int k = 0; k < slot; k++)
            bit_out(k == slot-1, (k < SW) ? lb[SW-1-k] : 1'b1, (k == 0) ? h + extra : h, h);
        for (int k = 0; k < slot; k++)
            bit_out(k != slot-1, (k < SW) ? rb[SW-1-k] : 1'b1, h, h);
    endtask

    function automatic int expect_of(input logic [1:0] md, input int l, input int r);
        int s;
        s = l + r;
        case (md)
            2'b01:   return l;
            2'b10:   return r;
            2'b11:   return s >>> 1;
            default: return 0;
        endcase
    endfunction

    task automatic pick_vals(input int i, input int seed, output int l, output int r);
        case (i)
            0: begin l = 127;  r = 127;  end
            1: begin l = -128; r = -128; end
            2: begin l = 127;  r = -128; end
            3: begin l = -1;   r = 0;    end
            default: begin
                l = ((i * 37 + seed) % 256) - 128;
                r = ((i * 91 + 5 + seed * 3) % 256) - 128;
            end
        endcase
    endtask

    task automatic run_phase(input string req, input logic [1:0] md, input int n, input int skip,
                             input int h, input int extra, input int pad, input int seed);
        int l;
        int r;
        chan_mode = md;
        got_q.delete();
        exp_q.delete();
        for (int i = 0; i < n; i++) begin
            pick_vals(i, seed, l, r);
            send_frame(l, r, h, extra, pad);
            if (i >= skip) exp_q.push_back(expect_of(md, l, r));
        end
        repeat (30) @(negedge clk);
        chk({req, " R8 sample count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            chk(req, got_q[i], exp_q[i]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 band", int'(filt_band), 0);
        chk("R10 enable", int'(drive_en), 0);
        chk("R10 strobe", int'(mono_vld), 0);
        chk("R10 sample", int'(mono), 0);

        // R7 startup: two frames before the first sample
        run_phase("R7 startup", 2'b01, 6, 2, 4, 0, 0, 1);
        chk("R7 enable up", int'(drive_en), 1);

        // R1 R2 R3 sweeps with full-scale corners
        run_phase("R1 left", 2'b01, 44, 0, 4, 0, 0, 3);
        run_phase("R2 right", 2'b10, 44, 0, 4, 0, 0, 7);
        run_phase("R3 average", 2'b11, 44, 0, 4, 0, 0, 13);

        // R9 rate bands, period = 32*h + extra
        chk("R9 P=128 middle", int'(filt_band), 1);
        run_phase("R9 P=133", 2'b11, 5, 0, 4, 5, 0, 21);
        chk("R9 P=133 middle", int'(filt_band), 1);
        run_phase("R9 P=134", 2'b11, 5, 0, 4, 6, 0, 22);
        chk("R9 P=134 voice", int'(filt_band), 0);
        run_phase("R9 P=160", 2'b01, 5, 0, 5, 0, 0, 23);
        chk("R9 P=160 voice", int'(filt_band), 0);
        run_phase("R9 P=79", 2'b10, 5, 0, 2, 15, 0, 24);
        chk("R9 P=79 high", int'(filt_band), 2);
        run_phase("R9 P=80", 2'b10, 5, 0, 2, 16, 0, 25);
        chk("R9 P=80 middle", int'(filt_band), 1);
        run_phase("R9 P=64", 2'b11, 5, 0, 2, 0, 0, 26);
        chk("R9 P=64 high", int'(filt_band), 2);

        // R5 slots longer than the sample width
        run_phase("R5 padded slot", 2'b11, 10, 0, 4, 0, 4, 31);
        run_phase("R5 padded left", 2'b01, 6, 0, 3, 0, 2, 32);

        // R4 shutdown, then R7 re-arm after one frame
        run_phase("R4 shutdown", 2'b00, 4, 4, 4, 0, 0, 41);
        chk("R4 enable low", int'(drive_en), 0);
        chk("R4 sample zero", int'(mono), 0);
        run_phase("R7 after shutdown", 2'b01, 4, 1, 4, 0, 0, 42);
        chk("R7 enable back", int'(drive_en), 1);

        // R6 standby on bit-clock loss, then R7 recovery
        repeat (IDLE_CYC + 20) @(negedge clk);
        chk("R6 enable low", int'(drive_en), 0);
        chk("R6 sample zero", int'(mono), 0);
        run_phase("R7 after standby", 2'b10, 5, 2, 4, 0, 0, 51);
        chk("R7 enable restored", int'(drive_en), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule